// File: doc/BRIEF.md
# Internal Data Address Resolver

This block sits between the operand logic of a small 8-bit controller core and its 256-byte internal data space. Each request is one of four access kinds: a direct byte, an indirect byte, a working-register operand, or a single bit. The request also carries the active register bank. The resolver decides whether the access lands in internal RAM or on the bus to the special function registers. It computes the physical index and performs the access. For a bit write it reads the containing byte, replaces one bit and writes the byte back.

The parameter `EXTENDED` selects the variant. When it is 0, the part has 128 bytes of RAM, and the upper half of the address space holds only special function registers. When it is 1, the part has 256 bytes of RAM. In that variant the upper half is shared: direct accesses reach the registers and indirect accesses reach the extra RAM. The register functions themselves live outside the block, behind a simple port with a synchronous read.

The controller has four named states. `S_IDLE` waits for work. `S_ACCESS` drives the RAM or register port from the resolved target. `S_MERGE` writes back the byte with the one bit replaced. `S_DONE` presents the response for one cycle. Its transitions are:
- accept: `S_IDLE`→`S_ACCESS` when `req_valid` is high.
- finish: `S_ACCESS`→`S_DONE` for byte accesses and bit reads.
- modify: `S_ACCESS`→`S_MERGE` for bit writes.
- writeback: `S_MERGE`→`S_DONE`.
- retire: `S_DONE`→`S_IDLE`.

Top module: `idata_resolver`

## Requirements
- R1: After reset the block is idle. `busy`, `rsp_valid`, `sfr_rd` and `sfr_wr` are all low.
- R2: A direct access (`req_kind`=00) below 0x80 targets RAM at the same index. At 0x80 and above it targets the register port at the same address. `tgt_sel` reads 01 for RAM, 10 for the register port and 00 for no target.
- R3: An indirect access (`req_kind`=01) below 0x80 targets RAM. In the extended variant, 0x80 and above targets the upper RAM bytes at the same index. An indirect access never raises `sfr_rd` or `sfr_wr`.
- R4: In the base variant, an indirect access to 0x80 or above gives `tgt_sel`=00 and a response of 0xFF with `rsp_err` high. A write of this kind changes no storage.
- R5: A working-register access (`req_kind`=10) uses `req_addr[2:0]` as the register number n. It reaches RAM index `bank_sel`*8 + n.
- R6: A bit access (`req_kind`=11) to a bit address below 0x80 reaches RAM byte 0x20 + `addr[6:3]`, at bit `addr[2:0]`.
- R7: A bit access to bit address 0x80 or above reaches the register whose address is the bit address with its low three bits cleared. The bit position is `addr[2:0]`.
- R8: A bit write stores `req_wdata[0]` into the selected bit and leaves the other seven bits of the byte unchanged. It takes one cycle more than a byte access.
- R9: A bit read returns the selected bit in `rsp_data[0]`, with bits 7:1 zero. Any write returns 0x00.
- R10: `rsp_valid` rises in the cycle that follows the second clock edge after acceptance, or the third edge for a bit write. It stays high for exactly one cycle. Requests presented while `busy` is high are ignored.
- R11: A byte written in one mode reads back in another mode that reaches the same storage. Examples are a working register read directly, or low RAM read indirectly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_kind | input | 2 | 00 direct, 01 indirect, 10 working register, 11 bit |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Write byte; bit 0 is the value for a bit write |
| bank_sel | input | 2 | Active register bank |
| busy | output | 1 | An access is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 8 | Read result, 0xFF on error, 0x00 for writes |
| rsp_err | output | 1 | Access had no target |
| tgt_sel | output | 2 | Resolved target of the current access |
| phys_index | output | 8 | Resolved RAM index or register address |
| sfr_addr | output | 8 | Register port address |
| sfr_rd | output | 1 | Register read strobe; data expected on the next cycle |
| sfr_wr | output | 1 | Register write strobe |
| sfr_wdata | output | 8 | Register write data |
| sfr_rdata | input | 8 | Register read data, held until the next read |

## Verification
The bench drives one stimulus to both variants at once. It sweeps every address in every mode, every bank and register number, and every bit address with both values. A design that lets indirect accesses fall through to the register port would overwrite register contents, and the direct read-back sweep would show the changed values. A wrong bit-area base, or a missed clear of the low three bits for register bits, sends the bit to the wrong byte. A merge that writes the whole byte changes neighbouring bits, which the byte read-back after each bit write exposes. A controller that accepts requests while busy would corrupt a byte that the bench later reads back.

// File: rtl/idr_pkg.sv
package idr_pkg;

    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 8;
    localparam int BANK_W        = 2;
    localparam int REG_NUM_W     = 3;
    localparam int BIT_POS_W     = 3;
    localparam logic [ADDR_W-1:0] BIT_BYTE_BASE = 8'h20;
    localparam logic [DATA_W-1:0] ERR_READ_VAL  = 8'hFF;

    typedef enum logic [1:0] {
        K_DIRECT   = 2'b00,
        K_INDIRECT = 2'b01,
        K_REGISTER = 2'b10,
        K_BIT      = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        T_NONE = 2'b00,
        T_RAM  = 2'b01,
        T_SFR  = 2'b10
    } tgt_e;

    typedef struct packed {
        tgt_e                  tgt;
        logic [ADDR_W-1:0]     idx;
        logic [BIT_POS_W-1:0]  bitpos;
    } decode_t;

endpackage

// File: rtl/idr_decode.sv
module idr_decode
    import idr_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  acc_kind_e               kind,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BANK_W-1:0]       bank,
    output decode_t                 dec
);

    localparam int HI = ADDR_W - 1;

    logic upper_half;
    assign upper_half = addr[HI];

    always_comb begin
        dec.tgt    = T_RAM;
        dec.idx    = addr;
        dec.bitpos = addr[BIT_POS_W-1:0];
        unique case (kind)
            K_DIRECT: begin
                dec.tgt = upper_half ? T_SFR : T_RAM;
            end
            K_INDIRECT: begin
                if (upper_half) begin
                    dec.tgt = EXTENDED ? T_RAM : T_NONE;
                end
            end
            K_REGISTER: begin
                dec.idx = ADDR_W'({bank, addr[REG_NUM_W-1:0]});
            end
            K_BIT: begin
                if (upper_half) begin
                    dec.tgt = T_SFR;
                    dec.idx = {addr[HI:BIT_POS_W], {BIT_POS_W{1'b0}}};
                end else begin
                    dec.idx = BIT_BYTE_BASE + ADDR_W'(addr[HI-1:BIT_POS_W]);
                end
            end
        endcase
    end

    // R6: a low bit address must land inside the sixteen-byte bit area
    always_comb begin
        if (kind == K_BIT && !upper_half) begin
            p_bit_window_r6: assert (dec.idx >= BIT_BYTE_BASE &&
                                     dec.idx <  BIT_BYTE_BASE + 8'd16);
        end
    end

endmodule

// File: rtl/idr_ram.sv
module idr_ram #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       re,
    input  logic                       we,
    input  logic [$clog2(DEPTH)-1:0]   addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          q
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/idr_ctrl.sv
module idr_ctrl
    import idr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  acc_kind_e             req_kind,
    input  logic                  req_write,
    input  logic [DATA_W-1:0]     req_wdata,
    input  decode_t               dec,
    input  logic [DATA_W-1:0]     ram_q,
    input  logic [DATA_W-1:0]     sfr_rdata,
    output logic                  busy,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  rsp_err,
    output tgt_e                  tgt_sel,
    output logic [ADDR_W-1:0]     phys_index,
    output logic                  ram_re,
    output logic                  ram_we,
    output logic [DATA_W-1:0]     ram_wdata,
    output logic                  sfr_rd,
    output logic                  sfr_wr,
    output logic [DATA_W-1:0]     sfr_wdata
);

    typedef enum logic [1:0] {
        S_IDLE   = 2'b00,
        S_ACCESS = 2'b01,
        S_MERGE  = 2'b10,
        S_DONE   = 2'b11
    } state_e;

    state_e state, state_nx;

    acc_kind_e             kind_q;
    logic                  wr_q;
    tgt_e                  tgt_q;
    logic [ADDR_W-1:0]     idx_q;
    logic [BIT_POS_W-1:0]  bitpos_q;
    logic [DATA_W-1:0]     wdata_q;

    logic                  is_bit;
    logic [DATA_W-1:0]     rdata;
    logic [DATA_W-1:0]     merged;
    logic [DATA_W-1:0]     bit_mask;

    assign is_bit   = (kind_q == K_BIT);
    assign rdata    = (tgt_q == T_SFR) ? sfr_rdata : ram_q;
    assign bit_mask = DATA_W'(1) << bitpos_q;
    assign merged   = wdata_q[0] ? (rdata | bit_mask) : (rdata & ~bit_mask);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: accept, finish, modify, writeback, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_ACCESS;
            S_ACCESS: state_nx = (is_bit && wr_q) ? S_MERGE : S_DONE;
            S_MERGE:  state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
        endcase
    end

    // request capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= K_DIRECT;
            wr_q     <= 1'b0;
            tgt_q    <= T_NONE;
            idx_q    <= '0;
            bitpos_q <= '0;
            wdata_q  <= '0;
        end else if (state == S_IDLE && req_valid) begin
            kind_q   <= req_kind;
            wr_q     <= req_write;
            tgt_q    <= dec.tgt;
            idx_q    <= dec.idx;
            bitpos_q <= dec.bitpos;
            wdata_q  <= req_wdata;
        end
    end

    // outputs
    always_comb begin
        busy       = (state != S_IDLE);
        tgt_sel    = tgt_q;
        phys_index = idx_q;
        rsp_valid  = 1'b0;
        rsp_data   = '0;
        rsp_err    = 1'b0;
        ram_re     = 1'b0;
        ram_we     = 1'b0;
        sfr_rd     = 1'b0;
        sfr_wr     = 1'b0;
        ram_wdata  = wdata_q;
        sfr_wdata  = wdata_q;
        unique case (state)
            S_IDLE: begin
            end
            S_ACCESS: begin
                if (tgt_q == T_RAM) begin
                    ram_re = !wr_q || is_bit;
                    ram_we = wr_q && !is_bit;
                end else if (tgt_q == T_SFR) begin
                    sfr_rd = !wr_q || is_bit;
                    sfr_wr = wr_q && !is_bit;
                end
            end
            S_MERGE: begin
                ram_wdata = merged;
                sfr_wdata = merged;
                ram_we    = (tgt_q == T_RAM);
                sfr_wr    = (tgt_q == T_SFR);
            end
            S_DONE: begin
                rsp_valid = 1'b1;
                rsp_err   = (tgt_q == T_NONE);
                if (tgt_q == T_NONE) begin
                    rsp_data = ERR_READ_VAL;
                end else if (wr_q) begin
                    rsp_data = '0;
                end else if (is_bit) begin
                    rsp_data = DATA_W'(rdata[bitpos_q]);
                end else begin
                    rsp_data = rdata;
                end
            end
        endcase
    end

    // R2: never drive both storage ports in one cycle
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((ram_re || ram_we) && (sfr_rd || sfr_wr)));

    // R3: the register port is never reached through indirection
    p_no_indirect_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd || sfr_wr) |-> (kind_q != K_INDIRECT));

    // R4: an access without a target leaves both ports quiet
    p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && tgt_q == T_NONE) |-> !(ram_re || ram_we || sfr_rd || sfr_wr));

    // R8: write-back follows a read of the same byte
    p_merge_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MERGE) |-> $past(ram_re || sfr_rd));

    // R8: write-back alters at most one bit
    p_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MERGE) |-> ($countones(merged ^ rdata) <= 1));

    // R10: the response strobe lasts one cycle
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: busy falls only after a response
    p_busy_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rsp_valid));

endmodule

// File: rtl/idata_resolver.sv
module idata_resolver
    import idr_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_write,
    input  logic [7:0]    req_addr,
    input  logic [7:0]    req_wdata,
    input  logic [1:0]    bank_sel,
    output logic          busy,
    output logic          rsp_valid,
    output logic [7:0]    rsp_data,
    output logic          rsp_err,
    output logic [1:0]    tgt_sel,
    output logic [7:0]    phys_index,
    output logic [7:0]    sfr_addr,
    output logic          sfr_rd,
    output logic          sfr_wr,
    output logic [7:0]    sfr_wdata,
    input  logic [7:0]    sfr_rdata
);

    localparam int RAM_DEPTH = EXTENDED ? (1 << ADDR_W) : (1 << (ADDR_W - 1));
    localparam int RAM_AW    = $clog2(RAM_DEPTH);

    decode_t              dec;
    tgt_e                 tgt_int;
    logic                 ram_re;
    logic                 ram_we;
    logic [DATA_W-1:0]    ram_wdata;
    logic [DATA_W-1:0]    ram_q;
    logic [RAM_AW-1:0]    ram_addr;

    idr_decode #(
        .EXTENDED (EXTENDED)
    ) u_decode (
        .kind (acc_kind_e'(req_kind)),
        .addr (req_addr),
        .bank (bank_sel),
        .dec  (dec)
    );

    idr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (acc_kind_e'(req_kind)),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .dec        (dec),
        .ram_q      (ram_q),
        .sfr_rdata  (sfr_rdata),
        .busy       (busy),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_err    (rsp_err),
        .tgt_sel    (tgt_int),
        .phys_index (phys_index),
        .ram_re     (ram_re),
        .ram_we     (ram_we),
        .ram_wdata  (ram_wdata),
        .sfr_rd     (sfr_rd),
        .sfr_wr     (sfr_wr),
        .sfr_wdata  (sfr_wdata)
    );

    assign tgt_sel  = tgt_int;
    assign sfr_addr = phys_index;
    assign ram_addr = phys_index[RAM_AW-1:0];

    idr_ram #(
        .DEPTH  (RAM_DEPTH),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .re    (ram_re),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

endmodule

// File: tb/idata_resolver_test.sv
`timescale 1ns/1ps
module idata_resolver_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic       req_valid;
    logic [1:0] req_kind;
    logic       req_write;
    logic [7:0] req_addr;
    logic [7:0] req_wdata;
    logic [1:0] bank_sel;

    logic       busy_e, rv_e, err_e, srd_e, swr_e;
    logic [1:0] tg_e;
    logic [7:0] rd_e, ix_e, sa_e, swd_e, srq_e;
    logic       busy_b, rv_b, err_b, srd_b, swr_b;
    logic [1:0] tg_b;
    logic [7:0] rd_b, ix_b, sa_b, swd_b, srq_b;

    logic [7:0] sfrf_e [128];
    logic [7:0] sfrf_b [128];

    logic [7:0] exp_ram_e [256];
    logic [7:0] exp_ram_b [128];
    logic [7:0] exp_sfr_e [128];
    logic [7:0] exp_sfr_b [128];

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    idata_resolver #(.EXTENDED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .bank_sel(bank_sel), .busy(busy_e), .rsp_valid(rv_e), .rsp_data(rd_e),
        .rsp_err(err_e), .tgt_sel(tg_e), .phys_index(ix_e), .sfr_addr(sa_e),
        .sfr_rd(srd_e), .sfr_wr(swr_e), .sfr_wdata(swd_e), .sfr_rdata(srq_e));

    idata_resolver #(.EXTENDED(1'b0)) uut_base (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .bank_sel(bank_sel), .busy(busy_b), .rsp_valid(rv_b), .rsp_data(rd_b),
        .rsp_err(err_b), .tgt_sel(tg_b), .phys_index(ix_b), .sfr_addr(sa_b),
        .sfr_rd(srd_b), .sfr_wr(swr_b), .sfr_wdata(swd_b), .sfr_rdata(srq_b));

    // simple register files standing in for the special function registers
    always @(posedge clk) begin
        if (swr_e) sfrf_e[sa_e[6:0]] <= swd_e;
        if (srd_e) srq_e <= sfrf_e[sa_e[6:0]];
        if (swr_b) sfrf_b[sa_b[6:0]] <= swd_b;
        if (srd_b) srq_b <= sfrf_b[sa_b[6:0]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int f_tgt(input int ext, input int k, input int a);
        case (k)
            0: return (a < 128) ? 1 : 2;
            1: return (a < 128) ? 1 : (ext ? 1 : 0);
            2: return 1;
            default: return (a < 128) ? 1 : 2;
        endcase
    endfunction

    function automatic int f_idx(input int k, input int a, input int b);
        case (k)
            2: return b * 8 + (a % 8);
            3: return (a < 128) ? (32 + a / 8) : ((a / 8) * 8);
            default: return a;
        endcase
    endfunction

    // one access on both variants; intrude = present a stray write while busy
    task automatic do_op(input int k, input bit w, input int a, input int d,
                         input int b, input string req, input bit intrude);
        int tgx [2];
        int idx, bp, cur, nv, lat, n;
        int rs [2];
        int er [2];
        idx = f_idx(k, a, b);
        bp  = a % 8;
        lat = (k == 3 && w) ? 3 : 2;
        for (int v = 0; v < 2; v++) begin
            tgx[v] = f_tgt(v, k, a);
            er[v]  = 0;
            cur    = 0;
            if (tgx[v] == 0) begin
                rs[v] = 255;
                er[v] = 1;
            end else begin
                if (tgx[v] == 1) cur = v ? exp_ram_e[idx] : exp_ram_b[idx % 128];
                else             cur = v ? exp_sfr_e[idx % 128] : exp_sfr_b[idx % 128];
                if (w) begin
                    nv = (k == 3) ? ((cur & ~(1 << bp)) | ((d & 1) << bp)) : d;
                    if (tgx[v] == 1) begin
                        if (v) exp_ram_e[idx] = 8'(nv); else exp_ram_b[idx % 128] = 8'(nv);
                    end else begin
                        if (v) exp_sfr_e[idx % 128] = 8'(nv); else exp_sfr_b[idx % 128] = 8'(nv);
                    end
                    rs[v] = 0;
                end else begin
                    rs[v] = (k == 3) ? ((cur >> bp) & 1) : cur;
                end
            end
        end
        @(negedge clk);
        req_kind  = 2'(k);
        req_write = w;
        req_addr  = 8'(a);
        req_wdata = 8'(d);
        bank_sel  = 2'(b);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk(tg_e == 2'(tgx[1]), req, "ext target", tg_e, tgx[1]);
        chk(tg_b == 2'(tgx[0]), req, "base target", tg_b, tgx[0]);
        chk(ix_e == 8'(idx), req, "ext index", ix_e, idx);
        chk(ix_b == 8'(idx), req, "base index", ix_b, idx);
        if (intrude) begin
            req_kind  = 2'b00;
            req_write = 1'b1;
            req_addr  = 8'h10;
            req_wdata = 8'hEE;
            req_valid = 1'b1;
        end
        while (!rv_e && n < 8) begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end
        chk(n == lat, req, "latency", n, lat);
        chk(rv_b == 1'b1, req, "base rsp_valid", rv_b, 1);
        chk(rd_e == 8'(rs[1]), req, "ext data", rd_e, rs[1]);
        chk(rd_b == 8'(rs[0]), req, "base data", rd_b, rs[0]);
        chk(err_e == er[1][0], req, "ext err", err_e, er[1]);
        chk(err_b == er[0][0], req, "base err", err_b, er[0]);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_write = 1'b0;
        req_addr = 8'h00; req_wdata = 8'h00; bank_sel = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!busy_e && !busy_b, "R1", "busy", busy_e, 0);
        chk(!rv_e && !rv_b, "R1", "rsp_valid", rv_e, 0);
        chk(!srd_e && !swr_e && !srd_b && !swr_b, "R1", "sfr strobes", swr_e, 0);

        // R2: direct writes across the whole space
        for (int a = 0; a < 256; a++) do_op(0, 1, a, (a ^ 8'h5A) & 255, 0, "R2", 0);
        // R3 and R4: indirect writes to the upper half
        for (int a = 128; a < 256; a++) do_op(1, 1, a, (a * 3 + 1) & 255, 0, "R4", 0);
        // R2, R3, R11: read everything back both ways
        for (int a = 0; a < 256; a++) begin
            do_op(0, 0, a, 0, 0, "R2", 0);
            do_op(1, 0, a, 0, 0, "R3", 0);
        end
        // R10: a write offered while busy must be dropped
        do_op(0, 0, 5, 0, 0, "R10", 1);
        do_op(0, 0, 16, 0, 0, "R10", 0);
        // R5 and R11: working registers in every bank
        for (int b = 0; b < 4; b++) begin
            for (int n = 0; n < 8; n++) begin
                do_op(2, 1, n + 8 * (b + n), (b * 40 + n * 7 + 3) & 255, b, "R5", 0);
                do_op(0, 0, b * 8 + n, 0, 0, "R11", 0);
                do_op(2, 0, n, 0, b, "R5", 0);
            end
        end
        // R6, R7, R8, R9: bit writes with byte and bit read-back
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 256; a++) begin
                int val;
                val = ((a * 7) >> 2) & 1;
                if (pass == 1) val = 1 - val;
                do_op(3, 1, a, val, 0, (a < 128) ? "R6" : "R7", 0);
                do_op(3, 0, a, 0, 0, "R9", 0);
                do_op(0, 0, f_idx(3, a, 0), 0, 0, "R8", 0);
            end
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule